// File: doc/BRIEF.md
# Hardware Mutex Flag Bank

This block holds a bank of single-bit mutex flags. Several processors share it through a simple register bus. Each flag guards one shared resource. A processor claims a flag by reading that flag's register, so the claim is one bus access that cannot be split. A returned value of zero means the claim succeeded and the reader now owns the flag. A returned value of one means another agent already held it, and the state is left as it was. The owner frees the flag by writing zero to the same register.

A read-only status word reports how many flags the bank was built with, as a small code in its top nibble. Software reads that word once at start-up and then addresses the flags as consecutive 32-bit words above a fixed base. The flag count is a build-time parameter, restricted to 32, 64, 128 or 256. Any other value stops elaboration, so an invalid code can never appear in the status word.

Top module: `hwmutex_bank`

## Requirements
- R1: After reset every flag is free, bus_ready is low and bus_rdata is zero.
- R2: The status word is at byte offset 0x000 and flag i is at byte offset 0x100 + 4*i. Address bits 1:0 take no part in decoding.
- R3: A read of a free flag returns 0x00000000 and leaves the flag taken in the same cycle. A read in the very next cycle, including a strobe held for two cycles, returns 0x00000001.
- R4: A read of a taken flag returns 0x00000001 and leaves the flag taken.
- R5: A write of 0x00000000 to a flag register frees that flag. Other flags are unaffected.
- R6: A write of any nonzero value to a flag register changes nothing. A free flag stays free and a taken flag stays taken.
- R7: The status word is {code, 28'b0}, where code = log2(NUM_LOCKS) - 4. For 32 flags it reads 0x10000000. Writes to the status word are ignored.
- R8: A read of an unmapped offset returns zero and changes no flag. This covers 0x004 to 0x0FC, flag indices at or above NUM_LOCKS, and anything beyond. An index such as 32 must not alias flag 0.
- R9: When bus_rd and bus_wr are both high in one cycle, the write is applied first and the read then sees the result. Read plus write-zero on a taken flag returns 0 and leaves the flag taken. Read plus a nonzero write on a taken flag returns 1.
- R10: Every cycle with bus_rd or bus_wr high is answered by bus_ready high in the following cycle only. bus_rdata is registered, valid with that pulse, and zero whenever no read response is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_ready | output | 1 | One-cycle response pulse |

## Verification
The cases that are hardest to reach from the ports depend on exact cycle alignment. One is a read strobe held over two consecutive edges on the same free flag, which shows that the claim takes effect in the same cycle. Another is a read and a write-zero presented together on a taken flag, which shows the write-before-read ordering. The bench drives both directly from dedicated tasks instead of going through the single-access helpers. It then reads the flag back to confirm the state that remains. Aliasing is forced by reading offset 0x180, which would truncate to flag 0, and then claiming flag 0 to prove it was untouched.

// File: rtl/hwmutex_pkg.sv
package hwmutex_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned IDX_MAX_W    = 8;     // enough for 256 flags
    localparam int unsigned LOCK_BASE    = 256;   // byte offset of flag 0
    localparam int unsigned CODE_LSB     = 28;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_STATUS,
        TGT_LOCK
    } target_e;

    typedef struct packed {
        target_e                target;
        logic [IDX_MAX_W-1:0]   idx;
    } bus_access_t;

    function automatic bit count_ok(int unsigned n);
        return (n == 32) || (n == 64) || (n == 128) || (n == 256);
    endfunction

    function automatic logic [3:0] count_code(int unsigned n);
        case (n)
            32:      return 4'd1;
            64:      return 4'd2;
            128:     return 4'd3;
            256:     return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_word(int unsigned n);
        return {count_code(n), {CODE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/hwmutex_decode.sv
module hwmutex_decode
    import hwmutex_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_access_t       acc
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] FIRST_WORD = WORD_W'(LOCK_BASE / 4);
    localparam logic [WORD_W-1:0] END_WORD   = WORD_W'(LOCK_BASE / 4 + NUM_LOCKS);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] offset;

    assign word   = addr[ADDR_W-1:2];
    assign offset = word - FIRST_WORD;

    always_comb begin
        acc.target = TGT_NONE;
        acc.idx    = '0;
        if (word == '0) begin
            acc.target = TGT_STATUS;
        end else if (word >= FIRST_WORD && word < END_WORD) begin
            acc.target = TGT_LOCK;
            acc.idx    = IDX_MAX_W'(offset);
        end
    end

    initial begin
        a_cfg_addr_fits: assert (LOCK_BASE + 4 * NUM_LOCKS <= (1 << ADDR_W));
    end

    // R8: the reported flag index never reaches the configured count
    always_comb begin
        a_r8_idx_in_range: assert (acc.target != TGT_LOCK || 32'(acc.idx) < NUM_LOCKS);
    end

endmodule

// File: rtl/hwmutex_flags.sv
module hwmutex_flags
    import hwmutex_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              claim,      // read of a mapped flag
    input  logic              store,      // write to a mapped flag
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  idx,
    output logic              prev_held   // state seen by the read, after any write
);
    logic [NUM_LOCKS-1:0] held;
    logic                 release_req;

    assign release_req = store && (wdata == '0);

    // Write is ordered before the read of the same cycle.
    assign prev_held = release_req ? 1'b0 : held[idx];

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_flag
        logic sel;
        assign sel = (32'(idx) == i);
        always_ff @(posedge clk) begin
            if (rst) begin
                held[i] <= 1'b0;
            end else if (sel && claim) begin
                held[i] <= 1'b1;
            end else if (sel && release_req) begin
                held[i] <= 1'b0;
            end
        end
    end

    // R3/R4: any claim leaves the flag taken
    a_r3_claim_sets: assert property (@(posedge clk) disable iff (rst)
        claim |=> held[$past(idx)]);

    // R5: a lone release frees the flag
    a_r5_release_clears: assert property (@(posedge clk) disable iff (rst)
        (release_req && !claim) |=> !held[$past(idx)]);

    // R6: a nonzero write alone leaves every flag as it was
    a_r6_nonzero_write_inert: assert property (@(posedge clk) disable iff (rst)
        (store && !release_req && !claim) |=> held == $past(held));

    // R8: without a mapped access nothing moves
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!claim && !store) |=> $stable(held));

endmodule

// File: rtl/hwmutex_bank.sv
module hwmutex_bank
    import hwmutex_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready
);
    localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
    localparam logic [DATA_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

    bus_access_t acc;
    logic        lock_hit;
    logic        prev_held;

    hwmutex_decode #(
        .NUM_LOCKS (NUM_LOCKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .acc  (acc)
    );

    assign lock_hit = (acc.target == TGT_LOCK);

    hwmutex_flags #(
        .NUM_LOCKS (NUM_LOCKS)
    ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .claim     (bus_rd && lock_hit),
        .store     (bus_wr && lock_hit),
        .wdata     (bus_wdata),
        .idx       (acc.idx[IDX_W-1:0]),
        .prev_held (prev_held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_rd || bus_wr;
            bus_rdata <= '0;
            if (bus_rd) begin
                case (acc.target)
                    TGT_STATUS: bus_rdata <= STATUS_VAL;
                    TGT_LOCK:   bus_rdata <= DATA_W'(prev_held);
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

    initial begin
        a_cfg_lock_count: assert (count_ok(NUM_LOCKS));
    end

    // R10: every access gets exactly one ready pulse in the next cycle
    a_r10_ready_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |=> bus_ready);
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_ready);
    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

    // R7: a status read returns the count code
    a_r7_status_value: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && acc.target == TGT_STATUS) |=> bus_rdata == STATUS_VAL);

    // R8: unmapped reads return zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && acc.target == TGT_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/hwmutex_bank_test.sv
`timescale 1ns/1ps
module hwmutex_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hwmutex_bank #(.NUM_LOCKS(32), .ADDR_W(12)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    function automatic logic [11:0] lock_addr(int i);
        return 12'(256 + 4 * i);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One read; response sampled at the following negedge.
    task automatic rd_acc(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        chk("R10 ready on read", 32'(bus_ready), 32'd1);
    endtask

    task automatic wr_acc(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 ready on write", 32'(bus_ready), 32'd1);
        chk("R10 rdata zero on write", bus_rdata, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 ready after reset", 32'(bus_ready), 32'd0);
        chk("R1 rdata after reset", bus_rdata, 32'd0);
        for (int i = 0; i < 32; i++) begin
            rd_acc(lock_addr(i), d);
            chk("R1 flag free after reset", d, 32'd0);
            wr_acc(lock_addr(i), 32'd0);
        end
    endtask

    task automatic t_claim();
        logic [31:0] d;
        rd_acc(lock_addr(5), d); chk("R3 first claim", d, 32'd0);
        rd_acc(lock_addr(5), d); chk("R4 taken returns 1", d, 32'd1);
        rd_acc(lock_addr(5), d); chk("R4 stays taken", d, 32'd1);
        rd_acc(lock_addr(6), d); chk("R2 neighbour independent", d, 32'd0);
        rd_acc(12'h117, d);      chk("R2 low bits ignored", d, 32'd1);
        wr_acc(lock_addr(5), 0);
        wr_acc(lock_addr(6), 0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = lock_addr(9); bus_rd = 1'b1;
        @(negedge clk);
        chk("R3 b2b first ready", 32'(bus_ready), 32'd1);
        chk("R3 b2b first data", bus_rdata, 32'd0);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R3 b2b second ready", 32'(bus_ready), 32'd1);
        chk("R3 b2b second data", bus_rdata, 32'd1);
        wr_acc(lock_addr(9), 0);
        rd_acc(lock_addr(9), d); chk("R5 free after b2b", d, 32'd0);
        wr_acc(lock_addr(9), 0);
    endtask

    task automatic t_release();
        logic [31:0] d;
        rd_acc(lock_addr(12), d);
        rd_acc(lock_addr(31), d);
        wr_acc(lock_addr(12), 0);
        rd_acc(lock_addr(12), d); chk("R5 release frees", d, 32'd0);
        rd_acc(lock_addr(31), d); chk("R5 other flag untouched", d, 32'd1);
        wr_acc(lock_addr(12), 0);
        wr_acc(lock_addr(31), 0);
    endtask

    task automatic t_nonzero();
        logic [31:0] d;
        rd_acc(lock_addr(12), d);
        wr_acc(lock_addr(12), 32'hFFFF_FFFF);
        wr_acc(lock_addr(12), 32'd1);
        rd_acc(lock_addr(12), d); chk("R6 taken stays taken", d, 32'd1);
        wr_acc(lock_addr(13), 32'h8000_0000);
        rd_acc(lock_addr(13), d); chk("R6 free stays free", d, 32'd0);
        wr_acc(lock_addr(12), 0);
        wr_acc(lock_addr(13), 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        rd_acc(12'h000, d); chk("R7 status word", d, 32'h1000_0000);
        wr_acc(12'h000, 32'd0);
        wr_acc(12'h000, 32'hFFFF_FFFF);
        rd_acc(12'h000, d); chk("R7 status after writes", d, 32'h1000_0000);
        rd_acc(12'h002, d); chk("R2 status low bits ignored", d, 32'h1000_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd_acc(12'h004, d); chk("R8 gap start", d, 32'd0);
        rd_acc(12'h0FC, d); chk("R8 gap end", d, 32'd0);
        rd_acc(12'h180, d); chk("R8 index 32", d, 32'd0);
        rd_acc(12'h1FC, d); chk("R8 index 63", d, 32'd0);
        rd_acc(12'hFFC, d); chk("R8 top of space", d, 32'd0);
        rd_acc(lock_addr(0), d);  chk("R8 flag 0 not aliased", d, 32'd0);
        rd_acc(lock_addr(31), d); chk("R8 flag 31 not aliased", d, 32'd0);
        wr_acc(lock_addr(0), 0);
        wr_acc(lock_addr(31), 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        rd_acc(lock_addr(20), d);
        @(negedge clk);
        bus_addr = lock_addr(20); bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'd0;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk("R9 rd+wr0 returns 0", bus_rdata, 32'd0);
        rd_acc(lock_addr(20), d); chk("R9 rd+wr0 leaves taken", d, 32'd1);
        @(negedge clk);
        bus_addr = lock_addr(20); bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'd5;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk("R9 rd+nonzero returns 1", bus_rdata, 32'd1);
        wr_acc(lock_addr(20), 0);
    endtask

    task automatic t_ready();
        logic [31:0] d;
        rd_acc(lock_addr(3), d);
        chk("R10 read data valid", d, 32'd0);
        @(negedge clk);
        chk("R10 ready single pulse", 32'(bus_ready), 32'd0);
        chk("R10 rdata zero when idle", bus_rdata, 32'd0);
        wr_acc(lock_addr(3), 0);
        @(negedge clk);
        chk("R10 ready drops after write", 32'(bus_ready), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_claim();
        t_back_to_back();
        t_release();
        t_nonzero();
        t_status();
        t_unmapped();
        t_same_cycle();
        t_ready();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule